// File: doc/BRIEF.md
# Packed Depth Compare Unit

This block runs a packed depth test on two 64-bit words, one holding stored depths and one holding candidate depths. In short mode each word holds four unsigned 16-bit depths. In long mode each word holds two unsigned 32-bit depths. A field passes when its candidate value is less than or equal to the stored value.

Each issued operation produces two results. The first is the field-wise minimum, which becomes the updated depth word. The second is a set of pass bits, pushed in at the top of an 8-bit pixel write mask. Two short operations, or four long ones, therefore build a complete mask for a later pixel store. The field width is chosen by the mode input alone and does not depend on any pixel-size setting.

A pipelined form holds one result stage. When an operation is issued in this form, the depth output shows the minimum from the previous pipelined operation, and the new minimum waits in the stage. In both forms the mask is updated by the operation being issued.

Top module: `zdepth_cmp`

## Requirements
- R1: In short mode, field i occupies bits 16i+15..16i (i = 0..3). Its pass bit is 1 exactly when the srcB field is less than or equal to the srcA field, compared as unsigned numbers.
- R2: In long mode, field j occupies bits 32j+31..32j (j = 0..1). Its pass bit is 1 exactly when the srcB field is less than or equal to the srcA field, compared as unsigned numbers.
- R3: A non-pipelined issue (pipeMode = 0) puts the field-wise unsigned minimum of srcA and srcB on depthOut one clock edge after the issue. The field width follows longMode.
- R4: A short issue sets maskOut to {pass3, pass2, pass1, pass0, old[7:4]}, so field 0's pass bit lands in bit 4.
- R5: A long issue sets maskOut to {pass1, pass0, old[7:2]}, so field 0's pass bit lands in bit 6.
- R6: A pipelined issue (pipeMode = 1) puts the minimum held by the previous pipelined issue on depthOut one edge later. That value is 0 if no pipelined issue has happened since reset. The issue then stores its own minimum in the stage, and its pass bits still update maskOut in that same edge.
- R7: A non-pipelined issue leaves the stage untouched, so the next pipelined issue still returns the minimum from the last pipelined operation.
- R8: A cycle with issue = 0 leaves depthOut and maskOut unchanged.
- R9: Synchronous reset (rst = 1 at a clock edge) clears maskOut, depthOut and the pipeline stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| issue | input | 1 | Starts an operation in this cycle |
| longMode | input | 1 | 1 selects two 32-bit fields, 0 selects four 16-bit fields |
| pipeMode | input | 1 | 1 selects the one-stage pipelined form |
| srcA | input | 64 | Stored depth word |
| srcB | input | 64 | Candidate depth word |
| depthOut | output | 64 | Updated depth word |
| maskOut | output | 8 | Pixel write mask |

## Verification
Every result of an issue, whether the minimum, the stage hand-off or the mask shift, is due at the first rising edge after the issue. It is then held until the next issue or reset. The driver applies inputs at the falling edge and queues each expected item tagged with the cycle number one greater than the current one. The monitor checks an item on the falling edge once the edge counter reaches that number, which is half a period after the edge that produced it. Idle cycles queue items that expect the previous values, so the hold behaviour is checked on the same schedule.

// File: rtl/zdc_pkg.sv
package zdc_pkg;
  typedef struct packed {
    logic loadOut;     // capture a new depth result
    logic outFromStage; // depth result comes from the stage register
    logic loadStage;   // capture the new minimum into the stage
    logic shiftMask;   // push pass bits into the mask
    logic longSel;     // wide field layout
  } zdcStrobes_t;
endpackage

// File: rtl/zdc_ctrl.sv
module zdc_ctrl
  import zdc_pkg::*;
(
  input  logic        issue,
  input  logic        longMode,
  input  logic        pipeMode,
  output zdcStrobes_t strobes
);
  always_comb begin
    strobes.loadOut      = issue;
    strobes.outFromStage = pipeMode;
    strobes.loadStage    = issue & pipeMode;
    strobes.shiftMask    = issue;
    strobes.longSel      = longMode;
  end
endmodule

// File: rtl/zdc_datapath.sv
module zdc_datapath
  import zdc_pkg::*;
#(
  parameter int LANE_W = 16,
  parameter int LANES  = 4,
  parameter int MASK_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  zdcStrobes_t             strobes,
  input  logic [LANE_W*LANES-1:0] srcA,
  input  logic [LANE_W*LANES-1:0] srcB,
  output logic [LANE_W*LANES-1:0] depthOut,
  output logic [MASK_W-1:0]       maskOut
);
  localparam int DATA_W  = LANE_W * LANES;
  localparam int WIDE_N  = LANES / 2;
  localparam int WIDE_W  = LANE_W * 2;

  logic [LANES-1:0]  passNarrow;
  logic [WIDE_N-1:0] passWide;
  logic [DATA_W-1:0] minNarrow;
  logic [DATA_W-1:0] minWide;
  logic [DATA_W-1:0] minSel;
  logic [MASK_W-1:0] maskNext;
  logic [DATA_W-1:0] outQ;
  logic [DATA_W-1:0] stageQ;
  logic [MASK_W-1:0] maskQ;

  for (genvar i = 0; i < LANES; i++) begin : g_narrow
    logic [LANE_W-1:0] aLane;
    logic [LANE_W-1:0] bLane;
    assign aLane = srcA[i*LANE_W +: LANE_W];
    assign bLane = srcB[i*LANE_W +: LANE_W];
    assign passNarrow[i] = (bLane <= aLane);
    assign minNarrow[i*LANE_W +: LANE_W] = passNarrow[i] ? bLane : aLane;
  end

  for (genvar j = 0; j < WIDE_N; j++) begin : g_wide
    logic [WIDE_W-1:0] aLane;
    logic [WIDE_W-1:0] bLane;
    assign aLane = srcA[j*WIDE_W +: WIDE_W];
    assign bLane = srcB[j*WIDE_W +: WIDE_W];
    assign passWide[j] = (bLane <= aLane);
    assign minWide[j*WIDE_W +: WIDE_W] = passWide[j] ? bLane : aLane;
  end

  always_comb begin
    minSel = strobes.longSel ? minWide : minNarrow;
    if (strobes.longSel)
      maskNext = {passWide, maskQ[MASK_W-1:WIDE_N]};
    else
      maskNext = {passNarrow, maskQ[MASK_W-1:LANES]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outQ   <= '0;
      stageQ <= '0;
      maskQ  <= '0;
    end else begin
      if (strobes.loadOut)
        outQ <= strobes.outFromStage ? stageQ : minSel;
      if (strobes.loadStage)
        stageQ <= minSel;
      if (strobes.shiftMask)
        maskQ <= maskNext;
    end
  end

  assign depthOut = outQ;
  assign maskOut  = maskQ;
endmodule

// File: rtl/zdepth_cmp.sv
module zdepth_cmp
  import zdc_pkg::*;
#(
  parameter int LANE_W = 16,
  parameter int LANES  = 4,
  parameter int MASK_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    issue,
  input  logic                    longMode,
  input  logic                    pipeMode,
  input  logic [LANE_W*LANES-1:0] srcA,
  input  logic [LANE_W*LANES-1:0] srcB,
  output logic [LANE_W*LANES-1:0] depthOut,
  output logic [MASK_W-1:0]       maskOut
);
  zdcStrobes_t strobes;

  zdc_ctrl u_ctrl (
    .issue    (issue),
    .longMode (longMode),
    .pipeMode (pipeMode),
    .strobes  (strobes)
  );

  zdc_datapath #(
    .LANE_W (LANE_W),
    .LANES  (LANES),
    .MASK_W (MASK_W)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobes  (strobes),
    .srcA     (srcA),
    .srcB     (srcB),
    .depthOut (depthOut),
    .maskOut  (maskOut)
  );
endmodule

// File: rtl/zdepth_cmp_chk.sv
module zdepth_cmp_chk #(
  parameter int LANE_W = 16,
  parameter int LANES  = 4,
  parameter int MASK_W = 8
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    issue,
  input logic                    longMode,
  input logic                    pipeMode,
  input logic [LANE_W*LANES-1:0] srcA,
  input logic [LANE_W*LANES-1:0] srcB,
  input logic [LANE_W*LANES-1:0] depthOut,
  input logic [MASK_W-1:0]       maskOut
);
  localparam int WIDE_N = LANES / 2;

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (maskOut == '0 && depthOut == '0)); // R9
  AST_IDLE_MASK: assert property (@(posedge clk) disable iff (rst) !issue |=> $stable(maskOut)); // R8
  AST_IDLE_DEPTH: assert property (@(posedge clk) disable iff (rst) !issue |=> $stable(depthOut)); // R8
  AST_NARROW_SHIFT: assert property (@(posedge clk) disable iff (rst)
    (issue && !longMode) |=> maskOut[MASK_W-LANES-1:0] == $past(maskOut[MASK_W-1:LANES])); // R4
  AST_WIDE_SHIFT: assert property (@(posedge clk) disable iff (rst)
    (issue && longMode) |=> maskOut[MASK_W-WIDE_N-1:0] == $past(maskOut[MASK_W-1:WIDE_N])); // R5
  AST_MIN_BOUND: assert property (@(posedge clk) disable iff (rst)
    (issue && !pipeMode && !longMode) |=> depthOut[LANE_W-1:0] <= $past(srcA[LANE_W-1:0])); // R3
endmodule

bind zdepth_cmp zdepth_cmp_chk #(
  .LANE_W (LANE_W),
  .LANES  (LANES),
  .MASK_W (MASK_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .issue    (issue),
  .longMode (longMode),
  .pipeMode (pipeMode),
  .srcA     (srcA),
  .srcB     (srcB),
  .depthOut (depthOut),
  .maskOut  (maskOut)
);

// File: tb/sim_zdepth_cmp.sv
module sim_zdepth_cmp;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        issue = 1'b0;
  logic        longMode = 1'b0;
  logic        pipeMode = 1'b0;
  logic [63:0] srcA = '0;
  logic [63:0] srcB = '0;
  logic [63:0] depthOut;
  logic [7:0]  maskOut;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 1'b0;

  typedef struct {
    logic [63:0] depth;
    logic [7:0]  mask;
    int          due;
    string       tag;
  } expItem_t;

  expItem_t sbQueue[$];

  logic [63:0] modelStage = '0;
  logic [7:0]  modelMask = '0;
  logic [63:0] modelDepth = '0;

  zdepth_cmp u0 (
    .clk(clk), .rst(rst), .issue(issue), .longMode(longMode), .pipeMode(pipeMode),
    .srcA(srcA), .srcB(srcB), .depthOut(depthOut), .maskOut(maskOut)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [63:0] fieldMin(logic [63:0] a, logic [63:0] b, logic wide);
    logic [63:0] r;
    if (wide) begin
      for (int j = 0; j < 2; j++)
        r[j*32 +: 32] = (b[j*32 +: 32] <= a[j*32 +: 32]) ? b[j*32 +: 32] : a[j*32 +: 32];
    end else begin
      for (int i = 0; i < 4; i++)
        r[i*16 +: 16] = (b[i*16 +: 16] <= a[i*16 +: 16]) ? b[i*16 +: 16] : a[i*16 +: 16];
    end
    return r;
  endfunction

  function automatic logic [7:0] nextMask(logic [7:0] m, logic [63:0] a, logic [63:0] b, logic wide);
    logic [7:0] r;
    if (wide) begin
      r = m >> 2;
      for (int j = 0; j < 2; j++) r[6 + j] = (b[j*32 +: 32] <= a[j*32 +: 32]);
    end else begin
      r = m >> 4;
      for (int i = 0; i < 4; i++) r[4 + i] = (b[i*16 +: 16] <= a[i*16 +: 16]);
    end
    return r;
  endfunction

  task automatic checkNow(string tag, logic [63:0] expD, logic [7:0] expM);
    checks++;
    if (depthOut !== expD || maskOut !== expM) begin
      failures++;
      $display("FAIL %s depth=%h mask=%h expected depth=%h mask=%h", tag, depthOut, maskOut, expD, expM);
    end
  endtask

  // monitor: pops items whose due cycle has arrived
  always @(negedge clk) begin
    while (sbQueue.size() > 0 && sbQueue[0].due <= cyc) begin
      expItem_t it;
      it = sbQueue.pop_front();
      checkNow(it.tag, it.depth, it.mask);
    end
  end

  task automatic doOp(logic [63:0] a, logic [63:0] b, logic wide, logic pipe, string tag);
    expItem_t it;
    srcA = a; srcB = b; longMode = wide; pipeMode = pipe; issue = 1'b1;
    if (pipe) begin
      modelDepth = modelStage;
      modelStage = fieldMin(a, b, wide);
    end else begin
      modelDepth = fieldMin(a, b, wide);
    end
    modelMask = nextMask(modelMask, a, b, wide);
    it.depth = modelDepth; it.mask = modelMask; it.due = cyc + 1; it.tag = tag;
    sbQueue.push_back(it);
    @(posedge clk); @(negedge clk);
    issue = 1'b0;
  endtask

  task automatic doIdle(logic [63:0] a, logic [63:0] b, string tag);
    expItem_t it;
    srcA = a; srcB = b; issue = 1'b0;
    it.depth = modelDepth; it.mask = modelMask; it.due = cyc + 1; it.tag = tag;
    sbQueue.push_back(it);
    @(posedge clk); @(negedge clk);
  endtask

  task automatic doReset();
    rst = 1'b1; issue = 1'b0;
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
    modelStage = '0; modelMask = '0; modelDepth = '0;
    checkNow("R9 reset clears outputs", 64'h0, 8'h00);
  endtask

  initial begin
    @(negedge clk);
    doReset();
    // R1 R3 R4: short compares, equal / less / greater lanes
    doOp(64'h0010_0020_0030_0040, 64'h0010_0030_0020_0050, 1'b0, 1'b0, "R1 R3 R4 short mix");
    doOp(64'hFFFF_0000_8000_1234, 64'h0001_0000_7FFF_1235, 1'b0, 1'b0, "R1 R3 R4 short extremes");
    // R2 R5: long, unsigned top-bit cases, four in a row fill the mask
    doOp(64'h8000_0000_7FFF_FFFF, 64'h7FFF_FFFF_8000_0000, 1'b1, 1'b0, "R2 R3 R5 long unsigned");
    doOp(64'h0000_0005_0000_0005, 64'h0000_0005_0000_0006, 1'b1, 1'b0, "R2 R5 long equal/greater");
    doOp(64'h1234_5678_0000_0000, 64'h1234_5677_FFFF_FFFF, 1'b1, 1'b0, "R2 R5 long less/greater");
    doOp(64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0000, 1'b1, 1'b0, "R2 R5 long all pass");
    // R8: idle with changing inputs
    doIdle(64'h0, 64'hFFFF_FFFF_FFFF_FFFF, "R8 idle hold");
    doIdle(64'h5555_5555_5555_5555, 64'h0, "R8 idle hold again");
    // R6: pipelined sequence; first returns cleared stage
    doOp(64'h0100_0200_0300_0400, 64'h0050_0250_0300_0500, 1'b0, 1'b1, "R6 pipe first");
    doOp(64'h0000_0009_0000_0003, 64'h0000_0008_0000_0004, 1'b1, 1'b1, "R6 pipe second");
    // R7: scalar between pipelined ops keeps stage
    doOp(64'hAAAA_BBBB_CCCC_DDDD, 64'hBBBB_AAAA_DDDD_CCCC, 1'b0, 1'b0, "R7 scalar between");
    doOp(64'h0000_0000_0000_0001, 64'h0000_0000_0000_0002, 1'b0, 1'b1, "R6 R7 pipe after scalar");
    doIdle(64'h0, 64'h0, "R8 idle after pipe");
    // R9: mid-run reset clears the stage too
    doReset();
    doOp(64'h7777_7777_7777_7777, 64'h1111_1111_1111_1111, 1'b0, 1'b1, "R6 R9 pipe after reset");
    doOp(64'h0, 64'h0, 1'b0, 1'b1, "R6 pipe drain");
    doIdle(64'h0, 64'h0, "R8 final drain");
    @(negedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: run did not finish, expected completion");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule